// File: doc/BRIEF.md
# SD Host Vendor Register Bank

This block is the vendor extension of an SD host controller's register space. It sits on a little-endian memory-mapped bus that carries 1-, 2- and 4-byte accesses. It holds three local registers: an ADMA error/status word, control word 2 and control word 3. A fourth control word is decoded and always reads zero. Every other address passes through to the standard register file, which lies outside this block. The bank connects to that file through a forwarded write strobe, a read strobe and a read-data return.

On its way through, the bank changes some traffic. A write to the clock control register has its clock-stable bit replaced by a value that the bank works out itself. Reads of the buffer data port can be blocked by a bit in control word 2. The ADMA engine, also outside this block, reports a final block, a pause interrupt and an error state through dedicated set inputs. Software acknowledges the interrupt and restarts a paused transfer through the error/status word. The bank answers a valid restart with a single-cycle resume pulse.

Top module: `sdvb_bank`

## Requirements
- R1: Reset (active low, asynchronous) clears the error/status word, control word 2 and the paused flag, and loads control word 3 with 0x7F5F3F1F.
- R2: The word at 0x8C reads zero for every size and offset. Writes to it go to the standard register file.
- R3: The access size is coded 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, and the data sits in the low bytes of the bus. A write to control word 2 (0x80) or control word 3 (0x84) replaces only the addressed bytes, shifted by 8 × (address − word base). A read shifts the word right by the same amount and masks it to the access size.
- R4: While bit 6 of control word 2 is 1, reads of the buffer data port (0x20) return zero and are not forwarded. Other forwarded reads still return the standard file's data.
- R5: A write at exactly 0x2C is forwarded with bit 3 set to (written bit 2 AND card present). All other bits are forwarded unchanged.
- R6: A guarded write to the error/status word (0x54) leaves bit 10 unchanged. A write is guarded when it is 4 bytes wide, 2 bytes at 0x54, or 1 byte at 0x55.
- R7: A guarded write always stores bit 9 as 0.
- R8: In a guarded write, a 1 in bit 8 clears bit 8 and a 0 leaves it unchanged.
- R9: A guarded write with bit 9 = 1, made while the paused flag is set and the DMA select input is 2'b10, clears the paused flag. The resume output is then high for exactly the next cycle. With any other DMA select code, or with the flag clear, no pulse is issued.
- R10: Every other write to the error/status word is a plain byte merge of the addressed bytes, bits 8 to 10 included.
- R11: The engine inputs take priority over software in the same cycle. Set-final makes bit 10 = 1. Set-interrupt makes bit 8 = 1 and sets the paused flag. Error-load writes its 3-bit code into bits 2:0.
- R12: Writes to 0x54, 0x80 and 0x84 are not forwarded to the standard file. Writes to any other address are forwarded, and reads of any other address return the standard file's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | ADDR_W | Byte address within the register space |
| busSize | input | 2 | Access size code |
| busWrData | input | 32 | Write data, low-aligned |
| busRdData | output | 32 | Read data, low-aligned, masked to size |
| stdWrEn | output | 1 | Forwarded write strobe to the standard register file |
| stdWrData | output | 32 | Forwarded write data, clock-stable bit adjusted |
| stdRdEn | output | 1 | Forwarded read strobe |
| stdRdData | input | 32 | Read data from the standard register file |
| cardPresent | input | 1 | Card detected |
| dmaSel | input | 2 | DMA mode select from the host control register |
| admaSetFinal | input | 1 | Engine: mark final block |
| admaSetIrq | input | 1 | Engine: pause with interrupt |
| admaErrLoad | input | 1 | Engine: load error state |
| admaErrCode | input | 3 | Engine: error state code |
| admaResume | output | 1 | One-cycle resume request to the engine |
| admaPaused | output | 1 | Engine paused flag |
| ctrl2Value | output | 32 | Control word 2 contents |
| ctrl3Value | output | 32 | Control word 3 contents |

## Verification
The assertions run on every cycle. They check that the fourth control word and a blocked buffer port read zero, that local writes are never forwarded, that engine set inputs always show up in the status bits the next cycle, and that a resume pulse is only issued from the paused state and leaves the flag clear. The scenarios alone show the rest. These are the byte-lane arithmetic for each size and offset, the difference between guarded and plain writes to the status word, the write-one-to-clear and discarded continue bit, the clock-stable rewrite against card presence, and the DMA mode condition on resume.

// File: rtl/sdvb_pkg.sv
package sdvb_pkg;
  localparam int WORD_W = 32;
  localparam int LANES = WORD_W / 8;

  localparam int BIT_FINAL = 10;
  localparam int BIT_CONT = 9;
  localparam int BIT_IRQ = 8;
  localparam int BIT_CLK_EN = 2;
  localparam int BIT_CLK_STBL = 3;
  localparam int BIT_BUF_BLOCK = 6;

  localparam logic [1:0] DMA_ADMA2_32 = 2'b10;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_RSVD} accSize_e;
  typedef enum logic [2:0] {RD_STD, RD_ZERO, RD_ERR, RD_CTL2, RD_CTL3} rdSrc_e;

  typedef struct packed {
    logic wrErr;
    logic wrCtl2;
    logic wrCtl3;
    logic errGuard;
    logic [WORD_W-1:0] laneMask;
    logic [WORD_W-1:0] laneVal;
    rdSrc_e rdSrc;
    logic [4:0] rdShift;
    logic [WORD_W-1:0] rdMask;
  } bankStrobe_t;
endpackage

// File: rtl/sdvb_ctrl.sv
module sdvb_ctrl
  import sdvb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ERR_OFS = 'h54,
  parameter int CTL2_OFS = 'h80,
  parameter int CTL3_OFS = 'h84,
  parameter int CTL4_OFS = 'h8C,
  parameter int BUF_OFS = 'h20,
  parameter int CLK_OFS = 'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              cardPresent,
  input  logic [1:0]        dmaSel,
  input  logic              admaSetIrq,
  input  logic              bufBlock,
  output bankStrobe_t       strb,
  output logic              stdWrEn,
  output logic              stdRdEn,
  output logic [WORD_W-1:0] stdWrData,
  output logic              admaResume,
  output logic              admaPaused
);
  localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(ERR_OFS);
  localparam logic [ADDR_W-1:0] CTL2_A = ADDR_W'(CTL2_OFS);
  localparam logic [ADDR_W-1:0] CTL3_A = ADDR_W'(CTL3_OFS);
  localparam logic [ADDR_W-1:0] CTL4_A = ADDR_W'(CTL4_OFS);
  localparam logic [ADDR_W-1:0] BUF_A = ADDR_W'(BUF_OFS);
  localparam logic [ADDR_W-1:0] CLK_A = ADDR_W'(CLK_OFS);

  accSize_e accSize;
  logic [LANES-1:0] sizeLanes;
  logic [2*LANES-1:0] laneWide;
  logic [LANES-1:0] byteEn;
  logic [1:0] byteOfs;
  logic hitErr, hitCtl2, hitCtl3, hitCtl4, hitBuf, hitLocal;
  logic contHit;
  logic pausedQ, resumeQ;

  assign accSize = accSize_e'(busSize);
  assign byteOfs = busAddr[1:0];

  assign hitErr  = busAddr[ADDR_W-1:2] == ERR_A[ADDR_W-1:2];
  assign hitCtl2 = busAddr[ADDR_W-1:2] == CTL2_A[ADDR_W-1:2];
  assign hitCtl3 = busAddr[ADDR_W-1:2] == CTL3_A[ADDR_W-1:2];
  assign hitCtl4 = busAddr[ADDR_W-1:2] == CTL4_A[ADDR_W-1:2];
  assign hitBuf  = busAddr[ADDR_W-1:2] == BUF_A[ADDR_W-1:2];
  assign hitLocal = hitErr | hitCtl2 | hitCtl3;

  always_comb begin
    unique case (accSize)
      SZ_BYTE: sizeLanes = LANES'(4'b0001);
      SZ_HALF: sizeLanes = LANES'(4'b0011);
      default: sizeLanes = '1;
    endcase
    laneWide = {{LANES{1'b0}}, sizeLanes} << byteOfs;
    byteEn = laneWide[LANES-1:0];
  end

  always_comb begin
    strb = '0;
    for (int b = 0; b < LANES; b++) begin
      strb.laneMask[8*b +: 8] = {8{byteEn[b]}};
      strb.rdMask[8*b +: 8] = {8{sizeLanes[b]}};
    end
    strb.laneVal = busWrData << {byteOfs, 3'b000};
    strb.rdShift = {byteOfs, 3'b000};
    strb.wrErr = busWrEn & hitErr;
    strb.wrCtl2 = busWrEn & hitCtl2;
    strb.wrCtl3 = busWrEn & hitCtl3;
    strb.errGuard = accSize[1] ||
                    (accSize == SZ_HALF && byteOfs == 2'd0) ||
                    (accSize == SZ_BYTE && byteOfs == 2'd1);
    if (hitErr) strb.rdSrc = RD_ERR;
    else if (hitCtl2) strb.rdSrc = RD_CTL2;
    else if (hitCtl3) strb.rdSrc = RD_CTL3;
    else if (hitCtl4 || (hitBuf && bufBlock)) strb.rdSrc = RD_ZERO;
    else strb.rdSrc = RD_STD;
  end

  assign stdWrEn = busWrEn & ~hitLocal;
  assign stdRdEn = busRdEn & (strb.rdSrc == RD_STD);

  always_comb begin
    stdWrData = busWrData;
    if (busAddr == CLK_A)
      stdWrData[BIT_CLK_STBL] = busWrData[BIT_CLK_EN] & cardPresent;
  end

  assign contHit = strb.wrErr & strb.errGuard & strb.laneVal[BIT_CONT] &
                   (dmaSel == DMA_ADMA2_32);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pausedQ <= 1'b0;
      resumeQ <= 1'b0;
    end else begin
      resumeQ <= contHit & pausedQ;
      if (admaSetIrq) pausedQ <= 1'b1;
      else if (contHit) pausedQ <= 1'b0;
    end
  end

  assign admaResume = resumeQ;
  assign admaPaused = pausedQ;
endmodule

// File: rtl/sdvb_regs.sv
module sdvb_regs
  import sdvb_pkg::*;
#(
  parameter logic [31:0] CTL3_RST = 32'h7F5F3F1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [WORD_W-1:0] stdRdData,
  input  logic              admaSetFinal,
  input  logic              admaSetIrq,
  input  logic              admaErrLoad,
  input  logic [2:0]        admaErrCode,
  output logic [WORD_W-1:0] busRdData,
  output logic [WORD_W-1:0] errWord,
  output logic [WORD_W-1:0] ctl2Word,
  output logic [WORD_W-1:0] ctl3Word
);
  logic [WORD_W-1:0] errQ, ctl2Q, ctl3Q;
  logic [WORD_W-1:0] errNext, ctl2Next, ctl3Next;
  logic [WORD_W-1:0] rdWord;

  function automatic logic [WORD_W-1:0] laneMerge(input logic [WORD_W-1:0] oldV,
                                                  input logic [WORD_W-1:0] newV,
                                                  input logic [WORD_W-1:0] mask);
    return (oldV & ~mask) | (newV & mask);
  endfunction

  always_comb begin
    errNext = errQ;
    if (strb.wrErr) begin
      errNext = laneMerge(errQ, strb.laneVal, strb.laneMask);
      if (strb.errGuard) begin
        errNext[BIT_FINAL] = errQ[BIT_FINAL];
        errNext[BIT_CONT] = 1'b0;
        errNext[BIT_IRQ] = errQ[BIT_IRQ] & ~strb.laneVal[BIT_IRQ];
      end
    end
    if (admaSetFinal) errNext[BIT_FINAL] = 1'b1;
    if (admaSetIrq) errNext[BIT_IRQ] = 1'b1;
    if (admaErrLoad) errNext[2:0] = admaErrCode;
  end

  assign ctl2Next = strb.wrCtl2 ? laneMerge(ctl2Q, strb.laneVal, strb.laneMask) : ctl2Q;
  assign ctl3Next = strb.wrCtl3 ? laneMerge(ctl3Q, strb.laneVal, strb.laneMask) : ctl3Q;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= '0;
      ctl2Q <= '0;
      ctl3Q <= CTL3_RST;
    end else begin
      errQ <= errNext;
      ctl2Q <= ctl2Next;
      ctl3Q <= ctl3Next;
    end
  end

  always_comb begin
    unique case (strb.rdSrc)
      RD_ERR:  rdWord = errQ;
      RD_CTL2: rdWord = ctl2Q;
      RD_CTL3: rdWord = ctl3Q;
      RD_STD:  rdWord = stdRdData;
      default: rdWord = '0;
    endcase
  end

  assign busRdData = (strb.rdSrc == RD_STD) ? rdWord : ((rdWord >> strb.rdShift) & strb.rdMask);
  assign errWord = errQ;
  assign ctl2Word = ctl2Q;
  assign ctl3Word = ctl3Q;
endmodule

// File: rtl/sdvb_bank.sv
module sdvb_bank
  import sdvb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ERR_OFS = 'h54,
  parameter int CTL2_OFS = 'h80,
  parameter int CTL3_OFS = 'h84,
  parameter int CTL4_OFS = 'h8C,
  parameter int BUF_OFS = 'h20,
  parameter int CLK_OFS = 'h2C,
  parameter logic [31:0] CTL3_RST = 32'h7F5F3F1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              stdWrEn,
  output logic [31:0]       stdWrData,
  output logic              stdRdEn,
  input  logic [31:0]       stdRdData,
  input  logic              cardPresent,
  input  logic [1:0]        dmaSel,
  input  logic              admaSetFinal,
  input  logic              admaSetIrq,
  input  logic              admaErrLoad,
  input  logic [2:0]        admaErrCode,
  output logic              admaResume,
  output logic              admaPaused,
  output logic [31:0]       ctrl2Value,
  output logic [31:0]       ctrl3Value
);
  bankStrobe_t strb;
  logic [31:0] errWord;

  sdvb_ctrl #(
    .ADDR_W(ADDR_W), .ERR_OFS(ERR_OFS), .CTL2_OFS(CTL2_OFS), .CTL3_OFS(CTL3_OFS),
    .CTL4_OFS(CTL4_OFS), .BUF_OFS(BUF_OFS), .CLK_OFS(CLK_OFS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busSize(busSize), .busWrData(busWrData),
    .cardPresent(cardPresent), .dmaSel(dmaSel), .admaSetIrq(admaSetIrq),
    .bufBlock(ctrl2Value[BIT_BUF_BLOCK]), .strb(strb),
    .stdWrEn(stdWrEn), .stdRdEn(stdRdEn), .stdWrData(stdWrData),
    .admaResume(admaResume), .admaPaused(admaPaused)
  );

  sdvb_regs #(.CTL3_RST(CTL3_RST)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .stdRdData(stdRdData),
    .admaSetFinal(admaSetFinal), .admaSetIrq(admaSetIrq),
    .admaErrLoad(admaErrLoad), .admaErrCode(admaErrCode),
    .busRdData(busRdData), .errWord(errWord),
    .ctl2Word(ctrl2Value), .ctl3Word(ctrl3Value)
  );
endmodule

// File: rtl/sdvb_bank_chk.sv
module sdvb_bank_chk #(
  parameter int ADDR_W = 8,
  parameter int CTL2_OFS = 'h80,
  parameter int CTL4_OFS = 'h8C,
  parameter int BUF_OFS = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-3:0] wordAddr,
  input logic [31:0]       busRdData,
  input logic              stdWrEn,
  input logic              stdRdEn,
  input logic              bufBlock,
  input logic              admaSetFinal,
  input logic              admaSetIrq,
  input logic              admaResume,
  input logic              admaPaused,
  input logic              finalBit,
  input logic              irqBit
);
  localparam logic [ADDR_W-1:0] C2A = ADDR_W'(CTL2_OFS);
  localparam logic [ADDR_W-1:0] C4A = ADDR_W'(CTL4_OFS);
  localparam logic [ADDR_W-1:0] BFA = ADDR_W'(BUF_OFS);

  AST_CTRL4_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && wordAddr == C4A[ADDR_W-1:2]) |-> busRdData == 32'h0); // R2
  AST_BUF_PORT_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && wordAddr == BFA[ADDR_W-1:2] && bufBlock) |-> (busRdData == 32'h0 && !stdRdEn)); // R4
  AST_LOCAL_WRITE_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && wordAddr == C2A[ADDR_W-1:2]) |-> !stdWrEn); // R12
  AST_FINAL_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    admaSetFinal |=> finalBit); // R11
  AST_IRQ_SET_PAUSES: assert property (@(posedge clk) disable iff (!rstN)
    admaSetIrq |=> (irqBit && admaPaused)); // R11
  AST_RESUME_FROM_PAUSE: assert property (@(posedge clk) disable iff (!rstN)
    admaResume |-> $past(admaPaused)); // R9
  AST_RESUME_UNPAUSES: assert property (@(posedge clk) disable iff (!rstN)
    (admaResume && !$past(admaSetIrq)) |-> !admaPaused); // R9
endmodule

bind sdvb_bank sdvb_bank_chk #(
  .ADDR_W(ADDR_W), .CTL2_OFS(CTL2_OFS), .CTL4_OFS(CTL4_OFS), .BUF_OFS(BUF_OFS)
) uChk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .wordAddr(busAddr[ADDR_W-1:2]), .busRdData(busRdData),
  .stdWrEn(stdWrEn), .stdRdEn(stdRdEn), .bufBlock(ctrl2Value[6]),
  .admaSetFinal(admaSetFinal), .admaSetIrq(admaSetIrq),
  .admaResume(admaResume), .admaPaused(admaPaused),
  .finalBit(errWord[10]), .irqBit(errWord[8])
);

// File: tb/sdvb_bank_test.sv
`timescale 1ns/1ps
module sdvb_bank_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 0, busRdEn = 0;
  logic [7:0] busAddr = '0;
  logic [1:0] busSize = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData, stdWrData, ctrl2Value, ctrl3Value;
  logic stdWrEn, stdRdEn, admaResume, admaPaused;
  logic [31:0] stdRdData = 32'hCAFEF00D;
  logic cardPresent = 1'b1;
  logic [1:0] dmaSel = 2'b10;
  logic admaSetFinal = 0, admaSetIrq = 0, admaErrLoad = 0;
  logic [2:0] admaErrCode = '0;

  int checks = 0;
  int failures = 0;

  typedef struct { logic [31:0] exp; string tag; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  sdvb_bank uut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard entries as read data appears
  always @(negedge clk) begin
    if (busRdEn && rstN) begin
      if (expQ.size() == 0) check("scoreboard-empty", 32'h1, 32'h0);
      else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.tag, busRdData, it.exp);
      end
    end
  end

  task automatic busOp(input bit w, input bit r, input logic [7:0] a, input logic [1:0] s,
                       input logic [31:0] d, input bit fin, input bit irq, input bit ld,
                       input logic [2:0] code);
    busWrEn = w; busRdEn = r; busAddr = a; busSize = s; busWrData = d;
    admaSetFinal = fin; admaSetIrq = irq; admaErrLoad = ld; admaErrCode = code;
    @(posedge clk); #1;
    busWrEn = 0; busRdEn = 0; admaSetFinal = 0; admaSetIrq = 0; admaErrLoad = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
    busOp(1, 0, a, s, d, 0, 0, 0, 3'd0);
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp,
                    input string tag);
    expQ.push_back('{exp, tag});
    busOp(0, 1, a, s, 32'h0, 0, 0, 0, 3'd0);
  endtask

  task automatic wrStd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d,
                       input logic expEn, input logic [31:0] expData, input string tag);
    busWrEn = 1; busAddr = a; busSize = s; busWrData = d;
    @(negedge clk);
    check({tag, " fwd"}, {31'h0, stdWrEn}, {31'h0, expEn});
    if (expEn) check({tag, " data"}, stdWrData, expData);
    @(posedge clk); #1;
    busWrEn = 0;
  endtask

  task automatic applyReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    #1 rstN = 1;
  endtask

  initial begin
    #200000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    @(negedge clk); check("R1 paused", {31'h0, admaPaused}, 32'h0);
    @(posedge clk); #1;
    rd(8'h84, 2'd2, 32'h7F5F3F1F, "R1 ctrl3");
    rd(8'h80, 2'd2, 32'h0, "R1 ctrl2");
    rd(8'h54, 2'd2, 32'h0, "R1 err");
    // R2 ctrl4 zero, write forwarded
    wrStd(8'h8C, 2'd2, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, "R2 ctrl4 write");
    rd(8'h8C, 2'd2, 32'h0, "R2 ctrl4 word");
    rd(8'h8D, 2'd0, 32'h0, "R2 ctrl4 byte");
    // R3 byte lanes
    wr(8'h81, 2'd0, 32'h000000AB);
    rd(8'h80, 2'd2, 32'h0000AB00, "R3 ctrl2 word");
    rd(8'h81, 2'd0, 32'h000000AB, "R3 ctrl2 byte1");
    rd(8'h80, 2'd1, 32'h0000AB00, "R3 ctrl2 half");
    wr(8'h86, 2'd1, 32'h00001234);
    rd(8'h84, 2'd2, 32'h12343F1F, "R3 ctrl3 word");
    rd(8'h87, 2'd0, 32'h00000012, "R3 ctrl3 byte3");
    // R4 buffer port gating
    rd(8'h20, 2'd2, 32'hCAFEF00D, "R4 buf open");
    wr(8'h80, 2'd0, 32'h00000040);
    rd(8'h20, 2'd2, 32'h0, "R4 buf blocked");
    rd(8'h24, 2'd2, 32'hCAFEF00D, "R4 other std read");
    // R5 clock stable
    cardPresent = 1;
    wrStd(8'h2C, 2'd1, 32'h00000004, 1'b1, 32'h0000000C, "R5 en+card");
    cardPresent = 0;
    wrStd(8'h2C, 2'd1, 32'h00000004, 1'b1, 32'h00000004, "R5 no card");
    cardPresent = 1;
    wrStd(8'h2C, 2'd1, 32'h00000008, 1'b1, 32'h00000000, "R5 clk off");
    wrStd(8'h30, 2'd1, 32'h00000004, 1'b1, 32'h00000004, "R12 other addr");
    wrStd(8'h80, 2'd0, 32'h00000040, 1'b0, 32'h0, "R12 local ctrl2");
    wrStd(8'h54, 2'd0, 32'h00000000, 1'b0, 32'h0, "R12 local err");
    // R6 / R7
    busOp(0, 0, 8'h0, 2'd0, 32'h0, 1, 0, 0, 3'd0);
    rd(8'h54, 2'd2, 32'h00000400, "R11 final set");
    wr(8'h54, 2'd2, 32'h00000000);
    rd(8'h54, 2'd2, 32'h00000400, "R6 final kept");
    wr(8'h54, 2'd2, 32'h00000205);
    @(negedge clk); check("R9 no resume unpaused", {31'h0, admaResume}, 32'h0);
    @(posedge clk); #1;
    rd(8'h54, 2'd2, 32'h00000405, "R7 cont dropped");
    // R8 W1C
    busOp(0, 0, 8'h0, 2'd0, 32'h0, 0, 1, 0, 3'd0);
    rd(8'h54, 2'd2, 32'h00000505, "R11 irq set");
    wr(8'h55, 2'd0, 32'h00000000);
    rd(8'h54, 2'd2, 32'h00000505, "R8 zero keeps");
    wr(8'h55, 2'd0, 32'h00000001);
    rd(8'h54, 2'd2, 32'h00000405, "R8 one clears");
    // R9 resume
    dmaSel = 2'b01;
    wr(8'h55, 2'd0, 32'h00000002);
    @(negedge clk);
    check("R9 wrong mode no pulse", {31'h0, admaResume}, 32'h0);
    check("R9 wrong mode stays paused", {31'h0, admaPaused}, 32'h1);
    @(posedge clk); #1;
    dmaSel = 2'b10;
    wr(8'h55, 2'd0, 32'h00000002);
    @(negedge clk);
    check("R9 pulse", {31'h0, admaResume}, 32'h1);
    check("R9 unpaused", {31'h0, admaPaused}, 32'h0);
    @(negedge clk);
    check("R9 pulse one cycle", {31'h0, admaResume}, 32'h0);
    @(posedge clk); #1;
    rd(8'h54, 2'd2, 32'h00000405, "R7 cont not stored");
    // R10 plain merge
    wr(8'h56, 2'd1, 32'h0000BEEF);
    rd(8'h54, 2'd2, 32'hBEEF0405, "R10 upper half");
    wr(8'h55, 2'd1, 32'h00000300);
    rd(8'h54, 2'd2, 32'hBE030005, "R10 half at +1 clears bit10");
    wr(8'h54, 2'd0, 32'h00000007);
    rd(8'h54, 2'd2, 32'hBE030007, "R10 byte0");
    wr(8'h55, 2'd1, 32'h00000002);
    rd(8'h54, 2'd2, 32'hBE000207, "R10 cont stored plain");
    rd(8'h56, 2'd1, 32'h0000BE00, "R3 err half read");
    // R11 priority
    busOp(1, 0, 8'h54, 2'd0, 32'h00000002, 0, 0, 1, 3'd5);
    rd(8'h54, 2'd2, 32'hBE000205, "R11 code over sw");
    busOp(1, 0, 8'h55, 2'd0, 32'h00000001, 0, 1, 0, 3'd0);
    rd(8'h54, 2'd2, 32'hBE000105, "R11 irq over w1c");
    busOp(1, 0, 8'h55, 2'd1, 32'h00000000, 1, 0, 0, 3'd0);
    rd(8'h54, 2'd2, 32'hBE000405, "R11 final over plain");
    @(negedge clk); check("R11 paused by irq", {31'h0, admaPaused}, 32'h1);
    @(posedge clk); #1;
    // R1 mid-run reset
    applyReset();
    @(negedge clk); check("R1 paused after reset", {31'h0, admaPaused}, 32'h0);
    @(posedge clk); #1;
    rd(8'h84, 2'd2, 32'h7F5F3F1F, "R1 ctrl3 after reset");
    rd(8'h54, 2'd2, 32'h0, "R1 err after reset");
    rd(8'h80, 2'd2, 32'h0, "R1 ctrl2 after reset");
    repeat (2) @(posedge clk);
    check("scoreboard drained", expQ.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule